// File: doc/BRIEF.md
# Two-Plane Cached Page Program Sequencer

This block sits on the host side of an asynchronous 8-bit NAND flash bus. It carries out one step of a two-plane cached program. A step starts from one request. The request gives a block, a page, a starting column, two page payloads and a flag that says whether this pair of pages is the last of the run. The sequencer loads the first plane, parks that data with a dummy confirm, and waits for the device to come back ready. It then loads the second plane and closes the pair with either the cache confirm or the normal confirm.

After the closing confirm, the sequencer waits for ready/busy to go high. It then issues a status read and keeps strobing the status byte until the ready bit that applies to this step is set. From that byte it takes the pass/fail bit that applies and reports it. Every bus cycle is built from fixed clock counts for the low and high phases of the write or read strobe. Every wait has a cycle limit; if the limit runs out, the request ends with an error.

A host runs a sequence of requests with the last flag clear. It sets the flag on the final pair, and the sequencer then closes that pair with the normal confirm and checks the completion bits.

Top module: `nand_mpc_seq`

## Requirements
- R1: After reset the block is idle with ce_no, we_no and re_no high, cle_o, ale_o, dq_oe_o, busy_o and done_o low.
- R2: A request first emits command 0x80, then five address cycles, then NBYTES data cycles for page 0, then command 0x11.
- R3: The five address cycles carry the column low byte, the column high byte, then the row least significant byte first. The row is block<<(PG_W+1) | plane<<PG_W | page. The plane bit is 0 in the first address group and 1 in the second, and the block is the same in both groups.
- R4: Command 0x81 is issued only once rb_i is high, and no earlier than GUARD_CYC cycles after the wait begins.
- R5: After 0x81 come five address cycles, then NBYTES data cycles for page 1. The pair is then closed with 0x15 when last_i was 0, or with 0x10 when last_i was 1, and command 0x70 follows once rb_i is high.
- R6: Data byte k of a page is bits [8k+7:8k] of its payload, and the bytes are sent in ascending k.
- R7: Command cycles raise cle_o alone and address cycles raise ale_o alone. Data cycles raise neither. Every write strobe stays low for WE_LO clock cycles, and the device latches the byte on the rising edge.
- R8: For a final pair, the status byte is read again until bit 5 is 1. err_o then equals bit 0 of that byte, and earlier bytes with bit 5 clear are not judged.
- R9: For an intermediate pair, the status byte is read again until bit 6 is 1. err_o then equals bit 1 of that byte.
- R10: If rb_i stays low, or the needed status bit stays clear, for TMO_CYC cycles, the request ends with err_o=1 and no further command is issued.
- R11: busy_o rises in the cycle after start_i is accepted. done_o is a one-cycle pulse, and busy_o is low in the cycle after it.
- R12: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled when idle |
| last_i | input | 1 | This pair is the final one |
| block_i | input | BLK_W | Block address |
| page_i | input | PG_W | Page within block |
| col_i | input | COL_W | First column to load |
| data0_i | input | 8*NBYTES | Payload for the plane-0 page |
| data1_i | input | 8*NBYTES | Payload for the plane-1 page |
| rb_i | input | 1 | Device ready (1) / busy (0) |
| dq_i | input | 8 | Data bus from device |
| ce_no | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| dq_o | output | 8 | Data bus to device |
| dq_oe_o | output | 1 | Drive enable for dq_o |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Result of last request, valid at done_o |

## Verification
If the byte index or the sequencer state is wrong, the bus log shows it within one strobe. A byte may be missing or repeated, a field may be misplaced, or the plane bit may sit in the wrong group, and the bench compares every latched byte with its arithmetic expectation. If the status decode is wrong, err_o or the number of status read strobes is off when done_o fires. The status model holds back the ready bits for a chosen number of reads and puts decoy values in the fail bits. A broken wait or timeout path shows up as an 0x81 issued while busy, or as a request that never ends or ends without an error.

// File: rtl/nand_mpc_pkg.sv
package nand_mpc_pkg;
  typedef enum logic [1:0] {K_CMD, K_ADR, K_WR, K_RD} cyc_kind_e;

  localparam logic [7:0] OP_LOAD1 = 8'h80;
  localparam logic [7:0] OP_DUMMY = 8'h11;
  localparam logic [7:0] OP_LOAD2 = 8'h81;
  localparam logic [7:0] OP_CACHE = 8'h15;
  localparam logic [7:0] OP_FINAL = 8'h10;
  localparam logic [7:0] OP_STAT  = 8'h70;

  typedef enum logic [3:0] {
    S_IDLE, S_C80, S_AD1, S_DT1, S_C11, S_WT1, S_C81,
    S_AD2, S_DT2, S_CFN, S_WT2, S_C70, S_STA, S_FIN
  } seq_st_e;
endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_mpc_pkg::*;
#(
  parameter int LO_CYC = 2,
  parameter int HI_CYC = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      go_i,
  input  cyc_kind_e kind_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] dq_i,
  output logic      idle_o,
  output logic      done_o,
  output logic [7:0] rd_byte_o,
  output logic      cle_o,
  output logic      ale_o,
  output logic      we_no,
  output logic      re_no,
  output logic [7:0] dq_o,
  output logic      dq_oe_o
);
  localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {P_IDLE, P_LO, P_HI} ph_e;
  ph_e         ph_q;
  logic [CW-1:0] cnt_q;
  cyc_kind_e   kind_q;
  logic [7:0]  byte_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= P_IDLE;
      cnt_q  <= '0;
      kind_q <= K_CMD;
      byte_q <= '0;
      rd_q   <= '0;
    end else begin
      unique case (ph_q)
        P_IDLE: if (go_i) begin
          ph_q   <= P_LO;
          cnt_q  <= CW'(LO_CYC - 1);
          kind_q <= kind_i;
          byte_q <= byte_i;
        end
        P_LO: if (cnt_q == '0) begin
          ph_q  <= P_HI;
          cnt_q <= CW'(HI_CYC - 1);
          if (kind_q == K_RD) rd_q <= dq_i;  // sample before strobe rises
        end else cnt_q <= cnt_q - 1'b1;
        P_HI: if (cnt_q == '0) ph_q <= P_IDLE;
              else cnt_q <= cnt_q - 1'b1;
        default: ph_q <= P_IDLE;
      endcase
    end
  end

  assign idle_o    = (ph_q == P_IDLE);
  assign done_o    = (ph_q == P_HI) && (cnt_q == '0);
  assign rd_byte_o = rd_q;
  assign cle_o     = (ph_q != P_IDLE) && (kind_q == K_CMD);
  assign ale_o     = (ph_q != P_IDLE) && (kind_q == K_ADR);
  assign we_no     = !((ph_q == P_LO) && (kind_q != K_RD));
  assign re_no     = !((ph_q == P_LO) && (kind_q == K_RD));
  assign dq_oe_o   = (ph_q != P_IDLE) && (kind_q != K_RD);
  assign dq_o      = byte_q;

  // R7
  cle_ale_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  // R7
  we_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> dq_oe_o && re_no);
  // R8
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !dq_oe_o && !cle_o && !ale_o);
endmodule

// File: rtl/nand_addr_fmt.sv
module nand_addr_fmt #(
  parameter int COL_W = 12,
  parameter int PG_W  = 6,
  parameter int BLK_W = 10
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [PG_W-1:0]  page_i,
  input  logic [BLK_W-1:0] block_i,
  input  logic             plane_i,
  input  logic [2:0]       idx_i,
  output logic [7:0]       byte_o
);
  localparam int ROW_W = BLK_W + 1 + PG_W;

  logic [15:0] col_x;
  logic [23:0] row_x;

  assign col_x = 16'(col_i);
  assign row_x = 24'({block_i, plane_i, page_i});

  always_comb begin
    unique case (idx_i)
      3'd0:    byte_o = col_x[7:0];
      3'd1:    byte_o = col_x[15:8];
      3'd2:    byte_o = row_x[7:0];
      3'd3:    byte_o = row_x[15:8];
      default: byte_o = row_x[23:16];
    endcase
  end

  initial begin
    fmt_fit_chk: assert (COL_W <= 16 && ROW_W <= 24);
  end
endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int TMO_CYC   = 200,
  parameter int GUARD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic rb_i,
  output logic ok_o,
  output logic tmo_o
);
  localparam int TW = $clog2(TMO_CYC + 1);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i)                cnt_q <= '0;
    else if (cnt_q != TW'(TMO_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o  = run_i && rb_i && (cnt_q >= TW'(GUARD_CYC));
  assign tmo_o = run_i && (cnt_q == TW'(TMO_CYC));

  // R10
  tmo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_o && run_i) |=> (tmo_o || !run_i));
endmodule

// File: rtl/nand_mpc_seq.sv
module nand_mpc_seq
  import nand_mpc_pkg::*;
#(
  parameter int COL_W     = 12,
  parameter int PG_W      = 6,
  parameter int BLK_W     = 10,
  parameter int NBYTES    = 4,
  parameter int WE_LO     = 2,
  parameter int WE_HI     = 2,
  parameter int GUARD_CYC = 2,
  parameter int TMO_CYC   = 200
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                last_i,
  input  logic [BLK_W-1:0]    block_i,
  input  logic [PG_W-1:0]     page_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [8*NBYTES-1:0] data0_i,
  input  logic [8*NBYTES-1:0] data1_i,
  input  logic                rb_i,
  input  logic [7:0]          dq_i,
  output logic                ce_no,
  output logic                cle_o,
  output logic                ale_o,
  output logic                we_no,
  output logic                re_no,
  output logic [7:0]          dq_o,
  output logic                dq_oe_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o
);
  localparam int IMAX = (NBYTES > 5) ? NBYTES : 5;
  localparam int IW   = $clog2(IMAX);
  localparam int DW   = 8 * NBYTES;

  seq_st_e           st_q;
  logic [IW-1:0]     idx_q;
  logic              err_q, last_q;
  logic [BLK_W-1:0]  blk_q;
  logic [PG_W-1:0]   pg_q;
  logic [COL_W-1:0]  col_q;
  logic [DW-1:0]     d0_q, d1_q;

  logic       go, eng_idle, eng_done, tm_run, tm_ok, tm_tmo;
  cyc_kind_e  kind;
  logic [7:0] out_byte, adr_byte, rd_byte;
  logic       need_bit, fail_bit;

  nand_addr_fmt #(.COL_W(COL_W), .PG_W(PG_W), .BLK_W(BLK_W)) u_fmt (
    .col_i(col_q), .page_i(pg_q), .block_i(blk_q),
    .plane_i(st_q == S_AD2), .idx_i(3'(idx_q)), .byte_o(adr_byte)
  );

  nand_wait_timer #(.TMO_CYC(TMO_CYC), .GUARD_CYC(GUARD_CYC)) u_tmr (
    .clk_i, .rst_ni, .run_i(tm_run), .rb_i, .ok_o(tm_ok), .tmo_o(tm_tmo)
  );

  nand_bus_cycle #(.LO_CYC(WE_LO), .HI_CYC(WE_HI)) u_cyc (
    .clk_i, .rst_ni, .go_i(go), .kind_i(kind), .byte_i(out_byte), .dq_i,
    .idle_o(eng_idle), .done_o(eng_done), .rd_byte_o(rd_byte),
    .cle_o, .ale_o, .we_no, .re_no, .dq_o, .dq_oe_o
  );

  always_comb begin
    go = 1'b1;
    kind = K_CMD;
    out_byte = 8'h00;
    unique case (st_q)
      S_C80: out_byte = OP_LOAD1;
      S_C11: out_byte = OP_DUMMY;
      S_C81: out_byte = OP_LOAD2;
      S_CFN: out_byte = last_q ? OP_FINAL : OP_CACHE;
      S_C70: out_byte = OP_STAT;
      S_AD1, S_AD2: begin kind = K_ADR; out_byte = adr_byte; end
      S_DT1: begin kind = K_WR; out_byte = d0_q[idx_q*8 +: 8]; end
      S_DT2: begin kind = K_WR; out_byte = d1_q[idx_q*8 +: 8]; end
      S_STA: kind = K_RD;
      default: go = 1'b0;
    endcase
  end

  assign tm_run   = (st_q == S_WT1) || (st_q == S_WT2) || (st_q == S_STA);
  assign need_bit = last_q ? rd_byte[5] : rd_byte[6];
  assign fail_bit = last_q ? rd_byte[0] : rd_byte[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; idx_q <= '0; err_q <= 1'b0; last_q <= 1'b0;
      blk_q <= '0; pg_q <= '0; col_q <= '0; d0_q <= '0; d1_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q <= S_C80; idx_q <= '0; err_q <= 1'b0; last_q <= last_i;
          blk_q <= block_i; pg_q <= page_i; col_q <= col_i;
          d0_q <= data0_i; d1_q <= data1_i;
        end
        S_C80: if (eng_done) st_q <= S_AD1;
        S_AD1, S_AD2: if (eng_done) begin
          if (idx_q == IW'(4)) begin
            idx_q <= '0;
            st_q  <= (st_q == S_AD1) ? S_DT1 : S_DT2;
          end else idx_q <= idx_q + 1'b1;
        end
        S_DT1, S_DT2: if (eng_done) begin
          if (idx_q == IW'(NBYTES - 1)) begin
            idx_q <= '0;
            st_q  <= (st_q == S_DT1) ? S_C11 : S_CFN;
          end else idx_q <= idx_q + 1'b1;
        end
        S_C11: if (eng_done) st_q <= S_WT1;
        S_WT1: if (tm_ok) st_q <= S_C81;
               else if (tm_tmo) begin err_q <= 1'b1; st_q <= S_FIN; end
        S_C81: if (eng_done) st_q <= S_AD2;
        S_CFN: if (eng_done) st_q <= S_WT2;
        S_WT2: if (tm_ok) st_q <= S_C70;
               else if (tm_tmo) begin err_q <= 1'b1; st_q <= S_FIN; end
        S_C70: if (eng_done) st_q <= S_STA;
        S_STA: if (eng_done) begin
          if (need_bit)    begin err_q <= fail_bit; st_q <= S_FIN; end
          else if (tm_tmo) begin err_q <= 1'b1;     st_q <= S_FIN; end
        end
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ce_no  = (st_q == S_IDLE) || (st_q == S_FIN);
  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_FIN);
  assign err_o  = err_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  // R11
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  // R4
  load2_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cle_o && !we_no && dq_o == OP_LOAD2) |-> rb_i);
  // R7
  strobe_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !re_no) |-> !ce_no);
  // R12
  payload_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(d0_q) && $stable(blk_q));
endmodule

// File: tb/nand_mpc_seq_tb.sv
module nand_mpc_seq_tb;
  localparam int COL_W = 12, PG_W = 6, BLK_W = 10, NBYTES = 4;
  localparam int WE_LO = 2, WE_HI = 2, GUARD_CYC = 2, TMO_CYC = 200;
  localparam int DW = 8 * NBYTES;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, last_i = 0;
  logic [BLK_W-1:0] block_i = '0;
  logic [PG_W-1:0]  page_i = '0;
  logic [COL_W-1:0] col_i = '0;
  logic [DW-1:0]    data0_i = '0, data1_i = '0;
  logic rb_i;
  logic [7:0] dq_i;
  logic ce_no, cle_o, ale_o, we_no, re_no, dq_oe_o, busy_o, done_o, err_o;
  logic [7:0] dq_o;

  always #4 clk = ~clk;

  nand_mpc_seq #(.COL_W(COL_W), .PG_W(PG_W), .BLK_W(BLK_W), .NBYTES(NBYTES),
    .WE_LO(WE_LO), .WE_HI(WE_HI), .GUARD_CYC(GUARD_CYC), .TMO_CYC(TMO_CYC)) u_dut (
    .clk_i(clk), .rst_ni, .start_i, .last_i, .block_i, .page_i, .col_i,
    .data0_i, .data1_i, .rb_i, .dq_i, .ce_no, .cle_o, .ale_o, .we_no, .re_no,
    .dq_o, .dq_oe_o, .busy_o, .done_o, .err_o);

  int checks = 0, errors = 0, cycles = 0;

  // device model
  int busy_cnt = 0, busy_len = 5, rd_cnt = 0, hold_n = 0, we_low = 0, bad_w = 0;
  logic [7:0] st_early = 8'h00, st_late = 8'h60;
  logic we_prev = 1, re_prev = 1;
  int lg_n = 0;
  logic [1:0] lg_k [64];
  logic [7:0] lg_v [64];
  logic       lg_rb[64];
  logic [1:0] ex_k [64];
  logic [7:0] ex_v [64];
  int ex_n;

  assign rb_i = (busy_cnt == 0);
  assign dq_i = (rd_cnt < hold_n) ? st_early : st_late;

  always @(negedge clk) begin
    cycles <= cycles + 1;
    we_prev <= we_no;
    re_prev <= re_no;
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (!we_no) we_low <= we_low + 1;
    if (we_no && !we_prev && !ce_no) begin
      if (we_low != WE_LO) bad_w <= bad_w + 1;
      we_low <= 0;
      if (lg_n < 64) begin
        lg_k[lg_n] <= {cle_o, ale_o};
        lg_v[lg_n] <= dq_o;
        lg_rb[lg_n] <= rb_i;
        lg_n <= lg_n + 1;
      end
      if (cle_o && (dq_o == 8'h11 || dq_o == 8'h15 || dq_o == 8'h10))
        busy_cnt <= busy_len;
    end
    if (re_no && !re_prev) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input int v);
    ex_k[ex_n] = k; ex_v[ex_n] = 8'(v); ex_n++;
  endtask

  task automatic build_exp(input int blk, input int pg, input int col,
                           input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                           input bit last, input bit full);
    ex_n = 0;
    for (int p = 0; p < 2; p++) begin
      int row;
      row = (blk << (PG_W + 1)) | (p << PG_W) | pg;
      push(2'b10, p == 0 ? 8'h80 : 8'h81);
      push(2'b01, col & 255);
      push(2'b01, (col >> 8) & 255);
      push(2'b01, row & 255);
      push(2'b01, (row >> 8) & 255);
      push(2'b01, (row >> 16) & 255);
      for (int k = 0; k < NBYTES; k++)
        push(2'b00, p == 0 ? int'(d0[8*k +: 8]) : int'(d1[8*k +: 8]));
      if (p == 0) begin
        push(2'b10, 8'h11);
        if (!full) return;
      end
    end
    push(2'b10, last ? 8'h10 : 8'h15);
    push(2'b10, 8'h70);
  endtask

  task automatic cmp_log();
    chk(lg_n == ex_n, "R2", "bus cycle count", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      string r;
      if (ex_k[i] == 2'b01) r = "R3";
      else if (ex_k[i] == 2'b00) r = "R6";
      else r = (i < 7 + NBYTES) ? "R2" : "R5";
      chk(lg_k[i] == ex_k[i], "R7", $sformatf("strobe kind #%0d", i), lg_k[i], ex_k[i]);
      chk(lg_v[i] == ex_v[i], r, $sformatf("bus byte #%0d", i), lg_v[i], ex_v[i]);
      if (ex_k[i] == 2'b10 && ex_v[i] == 8'h81)
        chk(lg_rb[i] == 1'b1, "R4", "0x81 while busy", lg_rb[i], 1);
    end
    chk(bad_w == 0, "R7", "write strobe low width errors", bad_w, 0);
  endtask

  task automatic run(input int blk, input int pg, input int col,
                     input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                     input bit last, input bit poke, output bit err);
    int lim;
    @(negedge clk);
    lg_n = 0; rd_cnt = 0; bad_w = 0; we_low = 0; busy_cnt = 0;
    block_i = BLK_W'(blk); page_i = PG_W'(pg); col_i = COL_W'(col);
    data0_i = d0; data1_i = d1; last_i = last; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk(busy_o == 1'b1, "R11", "busy after start", busy_o, 1);
    lim = 0;
    while (!done_o && lim < 5000) begin
      if (poke && lim == 20) begin
        // R12: a second request mid-run must change nothing
        start_i = 1; block_i = ~block_i; data0_i = ~data0_i; last_i = ~last;
      end else if (poke && lim == 21) start_i = 0;
      @(negedge clk);
      lim++;
    end
    start_i = 0;
    chk(done_o == 1'b1, "R11", "done reached", done_o, 1);
    err = err_o;
    @(negedge clk);
    chk(!done_o && !busy_o, "R11", "done one cycle then idle", {done_o, busy_o}, 0);
  endtask

  initial begin
    bit e;
    repeat (3) @(negedge clk);
    // R1
    chk({ce_no, we_no, re_no} == 3'b111, "R1", "strobes idle", {ce_no, we_no, re_no}, 7);
    chk({cle_o, ale_o, dq_oe_o, busy_o, done_o} == 0, "R1", "enables idle",
        {cle_o, ale_o, dq_oe_o, busy_o, done_o}, 0);
    rst_ni = 1;
    @(negedge clk);

    for (int t = 0; t < 12; t++) begin
      int blk, pg, col, hold;
      bit last, fail;
      logic [DW-1:0] d0, d1;
      last = t[0]; fail = t[1]; hold = t % 3;
      blk = (t * 97 + 3) % 1024; pg = (t * 13 + 1) % 64; col = (t * 331) % 4096;
      d0 = DW'(t) * 32'h01030507 + 32'h10203040;
      d1 = d0 ^ 32'hA55A3CC3;
      busy_len = 5 + t; hold_n = hold;
      // R8: early bytes carry a set bit 0 with bit 5 clear; R9: bit 1 set with bit 6 clear
      st_early = last ? 8'h41 : 8'h02;
      st_late  = last ? (8'h60 | 8'(fail)) : (8'h40 | (8'(fail) << 1));
      run(blk, pg, col, d0, d1, last, 1'b0, e);
      build_exp(blk, pg, col, d0, d1, last, 1'b1);
      cmp_log();
      chk(e == fail, last ? "R8" : "R9", "status result", e, fail);
      chk(rd_cnt == hold + 1, last ? "R8" : "R9", "status reads", rd_cnt, hold + 1);
    end

    // R10: device stays busy after the dummy confirm
    busy_len = 100000; hold_n = 0; st_late = 8'h60;
    run(21, 5, 64, 32'h01020304, 32'h05060708, 1'b1, 1'b0, e);
    build_exp(21, 5, 64, 32'h01020304, 32'h05060708, 1'b1, 1'b0);
    cmp_log();
    chk(e == 1'b1, "R10", "busy timeout error", e, 1);
    busy_cnt = 0;

    // R10: ready bit never appears in status
    busy_len = 4; hold_n = 100000; st_early = 8'h40;
    run(33, 9, 7, 32'hDEADBEEF, 32'h0BADF00D, 1'b1, 1'b0, e);
    build_exp(33, 9, 7, 32'hDEADBEEF, 32'h0BADF00D, 1'b1, 1'b1);
    cmp_log();
    chk(e == 1'b1, "R10", "status poll timeout error", e, 1);

    // R12: start pulse while busy is ignored
    busy_len = 6; hold_n = 1; st_early = 8'h00; st_late = 8'h40;
    run(700, 63, 4095, 32'hCAFEF00D, 32'h12345678, 1'b0, 1'b1, e);
    build_exp(700, 63, 4095, 32'hCAFEF00D, 32'h12345678, 1'b0, 1'b1);
    cmp_log();
    chk(e == 1'b0, "R12", "result unchanged by second start", e, 0);
    repeat (20) @(negedge clk);
    chk(!busy_o && lg_n == ex_n, "R12", "no extra request started", lg_n, ex_n);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule